// File: doc/BRIEF.md
# Double-Buffered BCD Time-of-Day and Calendar Registers

This block keeps the time of day (24-hour) and the calendar date in packed BCD. It holds two copies of the seven time fields. The running set advances on a once-per-second tick and never stops for host activity. The visible set is what the host reads. While transfers are enabled, the visible set follows the running set.

A host on a simple synchronous register bus can clear the transfer-enable bit in the control register. The visible set then freezes, so the host reads a coherent snapshot while the running set keeps counting underneath. While frozen, the host may overwrite any of the visible fields. When it sets transfer-enable again, only the fields it actually wrote are loaded into the running counters. Every other field keeps its running value, and the visible set resumes tracking in the same cycle.

A run/stop bit, kept in the top bit of the month register, gates the tick.

Top module: `bcd_tk_top`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 1, date 01, month 01 and year 00. The control register (address 0xF) reads 0x80: transfer-enable is bit 7 and reads 1. The stop bit reads 0.
- R2: While transfer-enable is 1, a read of address 0..6 returns the running count as it stands after the most recent clock edge.
- R3: Each accepted tick adds one second. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day. The field widths are seconds 7 bits (addr 0), minutes 7 bits (addr 1) and hours 6 bits (addr 2).
- R4: On a day carry, the date (6 bits, addr 4) wraps to 01 after the last day of the month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the two-digit year is divisible by four and 28 otherwise. Month (5 bits, addr 5) wraps from 12 to 01 and carries into the year (8 bits, addr 6). The year wraps from 99 to 00.
- R5: On a day carry, the weekday (3 bits, addr 3) advances, wrapping from 7 to 1.
- R6: A write of 0 to control bit 7 freezes the visible fields at the count current before that edge. While frozen they do not change on ticks, and the running count keeps advancing.
- R7: While frozen, a write to address 0..6 stores the value, masked to the field width, in the visible field. That value reads back at once.
- R8: A write of 1 to control bit 7 while frozen loads only the fields written during the freeze into the running counters. Unwritten fields keep their running values. The visible set then tracks again.
- R9: Bit 7 of the month register (addr 5) is the stop bit. A write to it takes effect in any state, and the bit reads back in that position. While it is 1, ticks are ignored.
- R10: While transfer-enable is 1, writes to addresses 0..6 leave every time field unchanged. The only effect is on the stop bit of address 5.
- R11: The control register reads transfer-enable in bit 7 and 0 in its other bits. Addresses 7 to 0xE read 0.
- R12: When a commit and an accepted tick fall in the same cycle, the tick is applied to the running count first, carries included. Written fields then take the host's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | ADDR_W (4) | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable, acts at the clock edge |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
A tick can land in the same cycle as a control write. In the commit case, the running carry chain and the host's written fields collide. The bench sets seconds to 59 and writes only the hours field while frozen. It then commits with the tick raised in that cycle. Minutes must carry, seconds must wrap and hours must take the written value. The freeze write is also issued together with a tick, and the frozen snapshot must hold the pre-tick count. In both cases the bench's behavioural model predicts every read, and reads are compared on each clock.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int DATA_W   = 8;
    localparam int N_FIELDS = 7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } tk_time_t;

    localparam tk_time_t TK_RESET = '{sec: 7'h00, min: 7'h00, hr: 6'h00,
                                      dow: 3'd1, date: 6'h01, mon: 5'h01,
                                      yr: 8'h00};

    // one-step BCD increment of a two-digit value, 99 wraps to 00
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'h0};
            if (r[7:4] >= 4'd10) r = 8'h00;
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic [7:0] field_get(input tk_time_t t, input logic [2:0] idx);
        logic [7:0] r;
        case (idx)
            3'd0:    r = {1'b0, t.sec};
            3'd1:    r = {1'b0, t.min};
            3'd2:    r = {2'b0, t.hr};
            3'd3:    r = {5'b0, t.dow};
            3'd4:    r = {2'b0, t.date};
            3'd5:    r = {3'b0, t.mon};
            3'd6:    r = t.yr;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic tk_time_t field_set(input tk_time_t t, input logic [2:0] idx,
                                           input logic [7:0] v);
        tk_time_t r;
        r = t;
        case (idx)
            3'd0:    r.sec  = v[6:0];
            3'd1:    r.min  = v[6:0];
            3'd2:    r.hr   = v[5:0];
            3'd3:    r.dow  = v[2:0];
            3'd4:    r.date = v[5:0];
            3'd5:    r.mon  = v[4:0];
            3'd6:    r.yr   = v;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tk_month_len.sv
module tk_month_len (
    input  logic [4:0] mon_i,
    input  logic [7:0] yr_i,
    output logic [5:0] last_day_o
);
    logic [7:0] yr_bin;
    logic       leap;

    always_comb begin
        yr_bin = ({4'b0, yr_i[7:4]} * 8'd10) + {4'b0, yr_i[3:0]};
        leap   = (yr_bin[1:0] == 2'b00);
        case (mon_i)
            5'h02:                      last_day_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 6'h30;
            default:                    last_day_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/tk_advance.sv
module tk_advance
    import tk_pkg::*;
(
    input  tk_time_t cur_i,
    input  logic     step_i,
    output tk_time_t nxt_o
);
    logic [5:0] last_day;
    logic       c_sec, c_min, c_hr, c_date, c_mon;
    logic [7:0] sec_inc, min_inc, hr_inc, date_inc, mon_inc, yr_inc;

    tk_month_len i_len (
        .mon_i      (cur_i.mon),
        .yr_i       (cur_i.yr),
        .last_day_o (last_day)
    );

    always_comb begin
        sec_inc  = bcd_inc({1'b0, cur_i.sec});
        min_inc  = bcd_inc({1'b0, cur_i.min});
        hr_inc   = bcd_inc({2'b0, cur_i.hr});
        date_inc = bcd_inc({2'b0, cur_i.date});
        mon_inc  = bcd_inc({3'b0, cur_i.mon});
        yr_inc   = bcd_inc(cur_i.yr);

        c_sec  = step_i & (cur_i.sec  == 7'h59);
        c_min  = c_sec  & (cur_i.min  == 7'h59);
        c_hr   = c_min  & (cur_i.hr   == 6'h23);
        c_date = c_hr   & (cur_i.date == last_day);
        c_mon  = c_date & (cur_i.mon  == 5'h12);

        nxt_o = cur_i;
        if (step_i) nxt_o.sec = c_sec ? 7'h00 : sec_inc[6:0];
        if (c_sec)  nxt_o.min = c_min ? 7'h00 : min_inc[6:0];
        if (c_min)  nxt_o.hr  = c_hr  ? 6'h00 : hr_inc[5:0];
        if (c_hr) begin
            nxt_o.dow  = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
            nxt_o.date = c_date ? 6'h01 : date_inc[5:0];
        end
        if (c_date) nxt_o.mon = c_mon ? 5'h01 : mon_inc[4:0];
        if (c_mon)  nxt_o.yr  = yr_inc;
    end
endmodule

// File: rtl/bcd_tk_top.sv
module bcd_tk_top
    import tk_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 15,
    parameter int MON_ADDR  = 5,
    parameter int TE_BIT    = 7,
    parameter int STOP_BIT  = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(MON_ADDR);
    localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(N_FIELDS);

    typedef struct packed {
        tk_time_t              run;
        tk_time_t              shadow;
        logic [N_FIELDS-1:0]   dirty;
        logic                  te;
        logic                  stop;
    } state_t;

    state_t   s_d, s_q;
    tk_time_t adv_time;
    logic     ctrl_wr, commit_w, field_wr;
    logic [2:0] fidx;

    tk_advance i_adv (
        .cur_i  (s_q.run),
        .step_i (tick_i & ~s_q.stop),
        .nxt_o  (adv_time)
    );

    always_comb begin
        fidx     = addr_i[2:0];
        ctrl_wr  = we_i && (addr_i == A_CTRL);
        commit_w = ctrl_wr && wdata_i[TE_BIT] && !s_q.te;
        field_wr = we_i && (addr_i < A_LIM);

        s_d     = s_q;
        s_d.run = adv_time;
        if (commit_w) begin
            for (int i = 0; i < N_FIELDS; i++) begin
                if (s_q.dirty[i])
                    s_d.run = field_set(s_d.run, 3'(i), field_get(s_q.shadow, 3'(i)));
            end
            s_d.dirty = '0;
        end
        if (we_i && (addr_i == A_MON))
            s_d.stop = wdata_i[STOP_BIT];
        if (field_wr && !s_q.te) begin
            s_d.shadow      = field_set(s_q.shadow, fidx, wdata_i);
            s_d.dirty[fidx] = 1'b1;
        end
        if (ctrl_wr)
            s_d.te = wdata_i[TE_BIT];
        if (s_d.te)
            s_d.shadow = s_d.run;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.run    <= TK_RESET;
            s_q.shadow <= TK_RESET;
            s_q.dirty  <= '0;
            s_q.te     <= 1'b1;
            s_q.stop   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i < A_LIM) begin
            rdata_o = field_get(s_q.shadow, fidx);
            if (addr_i == A_MON) rdata_o[STOP_BIT] = s_q.stop;
        end else if (addr_i == A_CTRL) begin
            rdata_o[TE_BIT] = s_q.te;
        end
    end

    AST_VISIBLE_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.te |-> (s_q.shadow == s_q.run)); // R2

    AST_FROZEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.te && !we_i) |=> $stable(s_q.shadow)); // R6

    AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.stop && !we_i) |=> $stable(s_q.run)); // R9

    AST_MIN_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i && s_q.run.sec != 7'h59) |=> $stable(s_q.run.min)); // R3

    AST_DIRTY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_w |=> (s_q.dirty == '0)); // R8

    AST_RUN_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.te && field_wr && !tick_i) |=> $stable(s_q.run)); // R10
endmodule

// File: tb/test_bcd_tk_top.sv
module test_bcd_tk_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic       we = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model: binary running fields, BCD visible bytes
    int       m_run [7];
    bit [7:0] m_vis [7];
    bit       m_dirty [7];
    bit       m_te, m_stop;
    bit [7:0] masks [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

    always #10 clk = ~clk;

    bcd_tk_top i_bcd_tk_top (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
        .wdata_i(wdata), .we_i(we), .rdata_o(rdata)
    );

    function automatic bit [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(bit [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_run = '{0, 0, 0, 1, 1, 1, 0};
        foreach (m_dirty[i]) m_dirty[i] = 0;
        m_te = 1; m_stop = 0;
        foreach (m_vis[i]) m_vis[i] = to_bcd(m_run[i]);
    endtask

    task automatic model_tick();
        m_run[0]++;
        if (m_run[0] < 60) return;
        m_run[0] = 0; m_run[1]++;
        if (m_run[1] < 60) return;
        m_run[1] = 0; m_run[2]++;
        if (m_run[2] < 24) return;
        m_run[2] = 0;
        m_run[3] = (m_run[3] == 7) ? 1 : m_run[3] + 1;
        m_run[4]++;
        if (m_run[4] <= days_in(m_run[5], m_run[6])) return;
        m_run[4] = 1; m_run[5]++;
        if (m_run[5] <= 12) return;
        m_run[5] = 1;
        m_run[6] = (m_run[6] + 1) % 100;
    endtask

    task automatic model_apply(bit [3:0] a, bit w, bit [7:0] d, bit t);
        bit old_te = m_te;
        if (t && !m_stop) model_tick();
        if (w && a == 4'hF && d[7] && !old_te) begin
            for (int i = 0; i < 7; i++) begin
                if (m_dirty[i]) m_run[i] = from_bcd(m_vis[i]);
                m_dirty[i] = 0;
            end
        end
        if (w && a == 4'h5) m_stop = d[7];
        if (w && a < 4'h7 && !old_te) begin
            m_vis[a] = d & masks[a];
            m_dirty[a] = 1;
        end
        if (w && a == 4'hF) m_te = d[7];
        if (m_te) for (int i = 0; i < 7; i++) m_vis[i] = to_bcd(m_run[i]);
    endtask

    function automatic bit [7:0] model_read(bit [3:0] a);
        if (a < 4'h7) return (a == 4'h5) ? (m_vis[a] | {m_stop, 7'b0}) : m_vis[a];
        if (a == 4'hF) return {m_te, 7'b0};
        return 8'h00;
    endfunction

    task automatic check_rd(bit [3:0] a);
        bit [7:0] exp = model_read(a);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0h actual %02h expected %02h", cur_req, a, rdata, exp);
        end
    endtask

    task automatic step(bit [3:0] a, bit w, bit [7:0] d, bit t);
        @(negedge clk);
        addr = a; we = w; wdata = d; tick = t;
        model_apply(a, w, d, t);
        @(posedge clk);
        #1;
        we = 1'b0; tick = 1'b0;
        check_rd(a);
    endtask

    task automatic read_all();
        for (int a = 0; a < 7; a++) step(4'(a), 1'b0, 8'h00, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic set_time(bit [7:0] s, bit [7:0] mi, bit [7:0] h, bit [7:0] dw,
                            bit [7:0] dt, bit [7:0] mo, bit [7:0] y);
        step(4'hF, 1'b1, 8'h00, 1'b0);
        step(4'h0, 1'b1, s, 1'b0);
        step(4'h1, 1'b1, mi, 1'b0);
        step(4'h2, 1'b1, h, 1'b0);
        step(4'h3, 1'b1, dw, 1'b0);
        step(4'h4, 1'b1, dt, 1'b0);
        step(4'h5, 1'b1, mo, 1'b0);
        step(4'h6, 1'b1, y, 1'b0);
        step(4'hF, 1'b1, 8'h80, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";  read_all();
        cur_req = "R11"; step(4'h7, 0, 0, 0); step(4'hC, 0, 0, 0); step(4'hF, 0, 0, 0);

        cur_req = "R2";
        for (int i = 0; i < 3; i++) step(4'h0, 1'b0, 8'h00, 1'b1);

        cur_req = "R3";
        set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h21);
        step(4'h0, 0, 0, 1); step(4'h0, 0, 0, 1); read_all();
        set_time(8'h59, 8'h09, 8'h19, 8'h02, 8'h10, 8'h03, 8'h05);
        step(4'h1, 0, 0, 1); read_all();

        cur_req = "R4";
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        step(4'h0, 0, 0, 1); read_all();
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        step(4'h4, 0, 0, 1); read_all();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        step(4'h4, 0, 0, 1); read_all();
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23);
        step(4'h4, 0, 0, 1); read_all();
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
        step(4'h4, 0, 0, 1); read_all();

        cur_req = "R5";
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h05, 8'h05, 8'h23);
        step(4'h3, 0, 0, 1);

        cur_req = "R6";
        step(4'hF, 1'b1, 8'h00, 1'b1);
        for (int i = 0; i < 5; i++) step(4'h0, 1'b0, 8'h00, 1'b1);
        read_all();

        cur_req = "R7";
        step(4'h1, 1'b1, 8'hC2, 1'b0);
        step(4'h1, 1'b0, 8'h00, 1'b1);

        cur_req = "R8";
        for (int i = 0; i < 3; i++) step(4'h0, 1'b0, 8'h00, 1'b1);
        step(4'hF, 1'b1, 8'h80, 1'b0);
        read_all();

        cur_req = "R9";
        step(4'h5, 1'b1, 8'h80, 1'b0);
        for (int i = 0; i < 3; i++) step(4'h0, 1'b0, 8'h00, 1'b1);
        read_all();
        step(4'h5, 1'b1, 8'h00, 1'b0);
        step(4'h0, 1'b0, 8'h00, 1'b1);

        cur_req = "R10";
        step(4'h0, 1'b1, 8'h30, 1'b0);
        step(4'h6, 1'b1, 8'h77, 1'b0);
        read_all();

        cur_req = "R11";
        step(4'hF, 1'b1, 8'h00, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0);
        step(4'h9, 1'b0, 8'h00, 1'b0);
        step(4'hF, 1'b1, 8'h80, 1'b0);

        cur_req = "R12";
        set_time(8'h59, 8'h10, 8'h12, 8'h01, 8'h01, 8'h01, 8'h30);
        step(4'hF, 1'b1, 8'h00, 1'b0);
        step(4'h2, 1'b1, 8'h05, 1'b0);
        step(4'hF, 1'b1, 8'h80, 1'b1);
        read_all();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule